// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host read and write a small set of configuration bytes over a four-wire serial link: a select line, a clock, data in and data out. The select line is active low. While it is low, the host sends a command byte and then a starting address byte. After that, data bytes flow in one direction, and the address moves forward by one after each byte. The transfer stops when the select line goes high.

The map has two kinds of register. A manufacturer identifier of 0x456 is built into the block. It is read-only and appears as two bytes, high byte first, zero-padded to 16 bits. There is also a row of writable configuration bytes, whose values appear in parallel on an output bus that drives control lines such as GPIO configuration. The serial inputs are brought into the system clock domain through two-stage synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `spi_cfg_slave`

## Requirements
- R1: The first byte after the select line falls is the command. Command 0x40 is a streaming read that returns the register at the address given by the second byte.
- R2: Address 0x01 reads 0x04 and address 0x02 reads 0x56. These two bytes are the 12-bit identifier 0x456, high byte first, zero-padded to 16 bits.
- R3: During a streaming read or write, the address increments by one after every 8 data bits and keeps going until the select line rises.
- R4: Command 0x80 is a streaming write. Each data byte is stored at the current address, and the address then increments. Configuration byte k sits at address 0x08+k (k = 0..3) and appears on `cfg_o[8k+7:8k]`.
- R5: A write to the identifier addresses, or to any unmapped address, leaves every configuration byte unchanged.
- R6: Every address other than 0x01, 0x02 and 0x08 to 0x0B reads as 0x00.
- R7: Bits move MSB first in SPI mode 0. SDI is sampled on the rising clock edge. SDO changes only after a falling edge and holds while the clock is high.
- R8: SDO is driven low whenever the select line is high.
- R9: When the select line rises in the middle of a byte, the partial byte is discarded and no write happens. The next transfer starts again with a command byte.
- R10: A command other than 0x40 or 0x80 causes no write, and SDO stays low for the rest of that transfer.
- R11: After reset, every configuration byte is 0x00 and SDO is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csb | input | 1 | Select, active low; framing of a transfer |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host, low while deselected |
| cfg_o | output | 32 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
The assertions assume that the serial inputs change slowly enough for the synchronized clock to show each level for at least two system cycles. They also assume that the select line toggles only while the serial clock is low. Given those assumptions, a falling edge seen after synchronization is the only point at which the output bit may change, and every write pulse is bounded by a selected transfer. The stimulus respects both assumptions. It holds each half of the serial clock for eight system cycles, changes data and select only while the clock is low, and leaves idle gaps between transfers. The one deliberate exception is the aborted transfer, which still raises select with the clock low.

// File: rtl/spi_cfg_pkg.sv
// Shared constants for the serial register-access slave.
// Assumes byte-wide registers and byte-wide addresses.
package spi_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] CMD_STREAM_RD = 8'h40;
    localparam logic [7:0] CMD_STREAM_WR = 8'h80;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/spi_cfg_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous input bits.
// Assumes each input bit is independent. Reset loads RST_VAL into every stage.
module spi_cfg_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cfg_engine.sv
// Protocol engine: detects serial clock edges, assembles bytes, decodes the
// command/address/data phases, issues write pulses and shifts read data out.
// Assumes synchronized inputs and a system clock at least 4x the serial clock.
module spi_cfg_engine
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    phase_t              phase_q;
    logic [CNT_W-1:0]    bit_q;
    logic [BYTE_W-2:0]   rx_q;
    logic [BYTE_W-1:0]   cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   tx_q;
    logic                sck_d;
    logic                sck_rise, sck_fall, byte_done;
    logic [BYTE_W-1:0]   rx_byte;

    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign rx_byte   = {rx_q, sdi_s};
    assign byte_done = (bit_q == CNT_W'(BYTE_W - 1));
    assign rd_addr   = addr_q;

    // Remember the previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Receive path, phase sequencing, address stepping and write pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CMD;
            bit_q   <= '0;
            rx_q    <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (csb_s) begin
                phase_q <= PH_CMD;
                bit_q   <= '0;
            end else if (sck_rise) begin
                rx_q  <= rx_byte[BYTE_W-2:0];
                bit_q <= bit_q + 1'b1;
                if (byte_done) begin
                    unique case (phase_q)
                        PH_CMD: begin
                            cmd_q   <= rx_byte;
                            phase_q <= PH_ADDR;
                        end
                        PH_ADDR: begin
                            addr_q  <= ADDR_W'(rx_byte);
                            phase_q <= PH_DATA;
                        end
                        default: begin
                            if (cmd_q == CMD_STREAM_WR) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= rx_byte;
                            end
                            addr_q <= addr_q + 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // Transmit path: load a byte at the first falling edge of each slot, shift after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            sdo_bit <= 1'b0;
        end else if (csb_s) begin
            sdo_bit <= 1'b0;
        end else if (sck_fall && phase_q == PH_DATA && cmd_q == CMD_STREAM_RD) begin
            if (bit_q == '0) begin
                sdo_bit <= rd_data[BYTE_W-1];
                tx_q    <= {rd_data[BYTE_W-2:0], 1'b0};
            end else begin
                sdo_bit <= tx_q[BYTE_W-1];
                tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_cfg_regs.sv
// Register bank: a hardwired identifier split over two bytes (high first) and
// NUM_CFG writable configuration bytes at CFG_BASE onward. Other addresses read 0.
// Assumes one-cycle write pulses. Reads are combinational.
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               NUM_CFG  = 4,
    parameter logic [ADDR_W-1:0] CFG_BASE = 8'h08,
    parameter logic [ADDR_W-1:0] ID_ADDR  = 8'h01,
    parameter logic [11:0]      MFG_ID   = 12'h456
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_o
);
    localparam logic [15:0] ID16 = {4'h0, MFG_ID};

    logic [BYTE_W-1:0] cfg_q [NUM_CFG];
    logic [ADDR_W-1:0] wr_off, rd_off;

    assign wr_off = wr_addr - CFG_BASE;
    assign rd_off = rd_addr - CFG_BASE;

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        // Store one configuration byte when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                cfg_q[k] <= '0;
            else if (wr_en && wr_off == ADDR_W'(k))    cfg_q[k] <= wr_data;
        end
        assign cfg_o[k*BYTE_W +: BYTE_W] = cfg_q[k];
    end

    // Read multiplexer over identifier bytes and configuration bytes.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ID_ADDR)                rd_data = ID16[15:8];
        else if (rd_addr == ID_ADDR + 1'b1)    rd_data = ID16[7:0];
        else begin
            for (int k = 0; k < NUM_CFG; k++)
                if (rd_off == ADDR_W'(k)) rd_data = cfg_q[k];
        end
    end
endmodule

// File: rtl/spi_cfg_slave.sv
// Top level of the serial register-access slave: synchronizes the serial pins,
// runs the protocol engine and hosts the register bank. SDO is gated low
// directly by the raw select line. Assumes clk >= 4x serial clock.
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int ADDR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_csb,
    input  logic                      spi_sck,
    input  logic                      spi_sdi,
    output logic                      spi_sdo,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_o
);
    logic [2:0]        pins_s;
    logic              csb_s, sck_s, sdi_s;
    logic              wr_en, sdo_bit;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    spi_cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csb, spi_sck, spi_sdi}),
        .q     (pins_s)
    );

    assign csb_s = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    spi_cfg_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .csb_s   (csb_s),
        .sck_s   (sck_s),
        .sdi_s   (sdi_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo_bit (sdo_bit)
    );

    spi_cfg_regs #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    assign spi_sdo = ~spi_csb & sdo_bit;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
// Checker for spi_cfg_slave, attached by bind. Watches the synchronized pins,
// the engine's output bit and the write port against the parallel outputs.
module spi_cfg_slave_chk #(
    parameter int              NUM_CFG  = 4,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_BASE = 8'h08
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 csb_s,
    input logic                 sck_s,
    input logic                 sdo_bit,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [7:0]           wr_data,
    input logic [NUM_CFG*8-1:0] cfg_o
);
    logic              sck_p;
    logic              fall_seen;
    logic [ADDR_W-1:0] off_now, off_last;
    logic              hit;
    logic [7:0]        cfg_at_last;

    assign off_now   = wr_addr - CFG_BASE;
    assign hit       = off_now < ADDR_W'(NUM_CFG);
    assign fall_seen = sck_p & ~sck_s;

    // Track the previous clock level and the last written offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p    <= 1'b0;
            off_last <= '0;
        end else begin
            sck_p <= sck_s;
            if (wr_en) off_last <= off_now;
        end
    end

    // Select the configuration byte that the last write aimed at.
    always_comb begin
        cfg_at_last = '0;
        for (int k = 0; k < NUM_CFG; k++)
            if (off_last == ADDR_W'(k)) cfg_at_last = cfg_o[k*8 +: 8];
    end

    assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csb_s |=> !sdo_bit);

    assert_sdo_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!csb_s && !fall_seen) |=> $stable(sdo_bit));

    assert_ignore_unmapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(cfg_o));

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> cfg_at_last == $past(wr_data));

    assert_write_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !csb_s);
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csb_s   (csb_s),
    .sck_s   (sck_s),
    .sdo_bit (sdo_bit),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg_o)
);

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csb = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic        sdo;
    logic [31:0] cfg;
    int          n_chk = 0, n_err = 0, glitches = 0;
    logic [7:0]  txb [8];
    logic [7:0]  rxb [8];

    always #10 clk = ~clk;

    spi_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_csb(csb), .spi_sck(sck),
        .spi_sdi(sdi), .spi_sdo(sdo), .cfg_o(cfg)
    );

    // {is_write, address, data (written or expected)}
    localparam logic [16:0] VEC [9] = '{
        {1'b1, 8'h08, 8'hA5}, {1'b0, 8'h08, 8'hA5},
        {1'b1, 8'h0B, 8'h3C}, {1'b0, 8'h0B, 8'h3C},
        {1'b0, 8'h01, 8'h04}, {1'b0, 8'h02, 8'h56},
        {1'b1, 8'h09, 8'hFF}, {1'b0, 8'h09, 8'hFF},
        {1'b0, 8'h0A, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] out, output logic [7:0] in);
        for (int i = 7; i >= 0; i--) begin
            logic a;
            sdi = out[i];
            wait_clk(HALF);
            a = sdo;
            in[i] = a;
            sck = 1'b1;
            wait_clk(HALF);
            if (sdo !== a) glitches++;
            sck = 1'b0;
        end
    endtask

    task automatic xact(input logic [7:0] cmd, input logic [7:0] addr, input int n);
        logic [7:0] dummy;
        csb = 1'b0;
        wait_clk(HALF);
        spi_byte(cmd, dummy);
        spi_byte(addr, dummy);
        for (int i = 0; i < n; i++) spi_byte(txb[i], rxb[i]);
        wait_clk(HALF);
        csb = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        #4_000_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait_clk(5);
        check("R11 cfg after reset", cfg, 32'h0);
        check("R11 sdo after reset", {31'b0, sdo}, 32'h0);
        rst_n = 1'b1;
        wait_clk(4);

        // Table walk: single-byte transfers (R1 read, R4 write)
        for (int v = 0; v < 9; v++) begin
            logic [16:0] e;
            e = VEC[v];
            txb[0] = e[7:0];
            if (e[16]) begin
                xact(8'h80, e[15:8], 1);
                check("R4 table write", {24'b0, cfg[(e[15:8]-8'h08)*8 +: 8]}, {24'b0, e[7:0]});
            end else begin
                txb[0] = 8'h00;
                xact(8'h40, e[15:8], 1);
                check("R1 table read", {24'b0, rxb[0]}, {24'b0, e[7:0]});
            end
        end
        check("R7 sdo held while sck high", glitches, 0);

        // Streaming read across ID bytes into unmapped space (R2, R3, R6)
        for (int i = 0; i < 3; i++) txb[i] = 8'h00;
        xact(8'h40, 8'h01, 3);
        check("R2 id high byte", {24'b0, rxb[0]}, 32'h04);
        check("R2 id low byte", {24'b0, rxb[1]}, 32'h56);
        check("R6 unmapped 0x03", {24'b0, rxb[2]}, 32'h00);

        // Streaming write of all config bytes then read back (R4, R3)
        txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txb[3] = 8'h44;
        xact(8'h80, 8'h08, 4);
        check("R4 streaming write", cfg, 32'h44332211);
        for (int i = 0; i < 4; i++) txb[i] = 8'h00;
        xact(8'h40, 8'h08, 4);
        check("R3 streaming read", {rxb[3], rxb[2], rxb[1], rxb[0]}, 32'h44332211);
        check("R8 sdo low when deselected", {31'b0, sdo}, 32'h0);

        // Writes to read-only and unmapped addresses (R5)
        txb[0] = 8'hFF; txb[1] = 8'hFF;
        xact(8'h80, 8'h01, 2);
        txb[0] = 8'h99;
        xact(8'h80, 8'h20, 1);
        check("R5 cfg unchanged", cfg, 32'h44332211);
        txb[0] = 8'h00; txb[1] = 8'h00;
        xact(8'h40, 8'h01, 2);
        check("R5 id intact", {16'b0, rxb[0], rxb[1]}, 32'h0456);
        xact(8'h40, 8'h20, 1);
        check("R6 unmapped 0x20", {24'b0, rxb[0]}, 32'h00);

        // Abort mid-byte (R9)
        begin
            logic [7:0] d;
            csb = 1'b0;
            wait_clk(HALF);
            spi_byte(8'h80, d);
            spi_byte(8'h08, d);
            for (int i = 0; i < 4; i++) begin
                sdi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
            end
            wait_clk(HALF);
            csb = 1'b1;
            wait_clk(HALF);
        end
        check("R9 partial byte dropped", cfg, 32'h44332211);
        txb[0] = 8'hC3;
        xact(8'h80, 8'h08, 1);
        check("R9 next transfer decodes", cfg, 32'h443322C3);

        // Unknown command (R10)
        txb[0] = 8'hEE; txb[1] = 8'hEE;
        xact(8'h00, 8'h08, 2);
        check("R10 no write", cfg, 32'h443322C3);
        check("R10 sdo stays low", {16'b0, rxb[0], rxb[1]}, 32'h0);

        // Reset mid-run clears the bank (R11)
        rst_n = 1'b0;
        wait_clk(3);
        check("R11 cfg cleared", cfg, 32'h0);
        rst_n = 1'b1;
        wait_clk(3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule